// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Sequencer

This block keeps the machine-level control state of a small 32-bit RISC-V core and decides, once per cycle, whether the instruction at the head of the pipeline retires normally, performs a CSR access, or is replaced by a trap. It serves CSR read/modify/write requests coming from the SYSTEM opcode. It also accepts exception reports from the pipeline, the ECALL/EBREAK/MRET/WFI system operations and a timer-pending level. When the flow of control changes, it drives a redirect strobe with the new fetch address.

The core supplies the PC of the instruction under consideration on `instPc`. On a trap the block saves that PC, the cause and a fault value. It pushes the interrupt-enable bit and the privilege level into the status register and sends fetch to the trap vector. `rdKill` then tells the pipeline to drop the destination write. MRET pops that stack. WFI raises a sleep flag, which the core uses to hold issue until the timer becomes pending. A free-running cycle counter can be read through the CSR port.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset the privilege is machine (3). Status, interrupt-enable, interrupt-pending, cause and the cycle counter read as zero, and `sleeping` is low.
- R2: The known CSR addresses are 0x300 status, 0x301 ISA word, 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 fault value, 0x344 interrupt pending, 0xC00 cycle and 0xF11 vendor word. Any other address, or a funct3 of 0 or 4, raises `csrIllegal` and takes an illegal-instruction trap (cause 2, fault value = `instPc`).
- R3: funct3 1 replaces the CSR with the source, 2 ORs the source into it, and 3 clears the source's bits. 5, 6 and 7 do the same with the zero-extended 5-bit `csrImm` as source. `csrRdata` always returns the value held before the operation.
- R4: The ISA word reads 0x40401101 and the vendor word reads 0xFF0FF0FF. Writes to these two and to the cycle address are dropped without a trap.
- R5: On any trap, MPIE (status bit 7) takes the old MIE (bit 3), MIE clears, MPP (bits 12:11) takes the old privilege, and the privilege becomes 3. The exception PC takes `instPc`, and `redirectPc` equals the trap vector in the same cycle.
- R6: A pipeline exception records `excCause`. ECALL records 11 from machine mode and 8 from user mode. EBREAK records 3.
- R7: The fault value takes `excAddr` for exception causes 5, 6 and 7, and `instPc` for every other exception.
- R8: A timer interrupt is taken only when pending bit 7, enable bit 7 and status MIE are all set. It records cause 0x80000007, fault value 0 and exception PC = `instPc`, and it wins over a concurrent exception.
- R9: MRET sets MIE to the old MPIE, sets MPIE to 1 and sets MPP to 0. It restores the privilege from the old MPP and redirects to the exception PC.
- R10: WFI sets status MIE, redirects to `instPc`+4 without a trap and raises `sleeping`. The first clock edge that sees `timerPending` high lowers `sleeping` again.
- R11: `rdKill` is high in exactly the cycles in which a trap is taken.
- R12: The cycle counter advances by one on every clock edge, and address 0xC00 returns its low 32 bits.
- R13: The status register stores only bits 3, 7 and 12:11, and its other bits read 0. The pending register shows `timerPending` (registered) at bit 7, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR access request this cycle |
| csrAddr | input | 12 | CSR address |
| csrOp | input | 3 | funct3 of the CSR instruction |
| csrSrc | input | 32 | rs1 register value |
| csrImm | input | 5 | rs1 field used as immediate |
| csrRdata | output | 32 | Old CSR value for the destination register |
| csrIllegal | output | 1 | Request has an unknown address or operation |
| excValid | input | 1 | Pipeline exception report |
| excCause | input | CAUSE_W | Exception cause code |
| excAddr | input | 32 | Faulting data address |
| sysValid | input | 1 | System operation this cycle |
| sysKind | input | 2 | 0 ECALL, 1 EBREAK, 2 MRET, 3 WFI |
| instPc | input | 32 | PC of the instruction under consideration |
| timerPending | input | 1 | Timer compare level |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | 32 | New fetch address |
| rdKill | output | 1 | Suppress destination write (trap taken) |
| privLevel | output | 2 | Current privilege, 3 machine, 0 user |
| sleeping | output | 1 | WFI sleep flag, hold issue |

## Verification
The read/modify/write path is swept over six functional codes, four base values and four source patterns. All-zero and all-one operands separate a true replace from set and clear, and mixed patterns expose swapped operands or an inverted mask. Every one of the 4096 addresses is probed, so a wrong or missing decode and any aliasing between registers both show up. Traps are driven with all sixteen cause codes, which tells the data-address fault values apart from the PC fault values. ECALL is issued from both privilege levels. The interrupt is tried with each enable missing in turn and then together with an exception, which checks both the gating and the priority.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam logic [11:0] ADDR_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_ISA     = 12'h301;
  localparam logic [11:0] ADDR_IE      = 12'h304;
  localparam logic [11:0] ADDR_TVEC    = 12'h305;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_EPC     = 12'h341;
  localparam logic [11:0] ADDR_CAUSE   = 12'h342;
  localparam logic [11:0] ADDR_TVAL    = 12'h343;
  localparam logic [11:0] ADDR_IP      = 12'h344;
  localparam logic [11:0] ADDR_CYCLE   = 12'hC00;
  localparam logic [11:0] ADDR_VENDOR  = 12'hF11;

  localparam word_t ISA_WORD    = 32'h4040_1101;
  localparam word_t VENDOR_WORD = 32'hFF0F_F0FF;
  localparam word_t TIMER_CAUSE = 32'h8000_0007;

  localparam int TIMER_BIT = 7;
  localparam int ST_IE     = 3;
  localparam int ST_PIE    = 7;
  localparam int ST_PP     = 11;

  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_U = 2'b00;

  localparam word_t CAUSE_ILLEGAL = 32'd2;
  localparam word_t CAUSE_BREAK   = 32'd3;
  localparam word_t CAUSE_CALL_U  = 32'd8;
  localparam word_t CAUSE_CALL_M  = 32'd11;

  typedef enum logic [1:0] {
    SYS_CALL  = 2'd0,
    SYS_BREAK = 2'd1,
    SYS_RET   = 2'd2,
    SYS_SLEEP = 2'd3
  } sysKind_e;

  typedef struct packed {
    logic trapEnter;
    logic trapIrq;
    logic mret;
    logic wfi;
    logic csrWrite;
  } ctlStrobe_t;

endpackage

// File: rtl/mcsr_dpath.sv
module mcsr_dpath
  import mcsr_pkg::*;
#(
  parameter int CYCLE_W = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [11:0] csrAddr,
  input  word_t      csrNewVal,
  input  word_t      trapCause,
  input  word_t      trapTval,
  input  word_t      instPc,
  input  logic       timerPending,
  output word_t      rdOld,
  output logic       addrKnown,
  output word_t      tvecOut,
  output word_t      epcOut,
  output logic       statusIe,
  output logic [1:0] privOut,
  output logic       pendTimer,
  output logic       enTimer,
  output logic       sleepOut
);

  localparam int LOW_W = (CYCLE_W < XLEN) ? CYCLE_W : XLEN;

  logic [CYCLE_W-1:0] cycleQ;
  logic        ieQ, pieQ;
  logic [1:0]  ppQ, privQ;
  logic        pendQ, sleepQ;
  word_t       enQ, tvecQ, scratchQ, epcQ, causeQ, tvalQ;
  word_t       statusView, pendView, cycleView;

  always_comb begin
    statusView = '0;
    statusView[ST_IE]        = ieQ;
    statusView[ST_PIE]       = pieQ;
    statusView[ST_PP +: 2]   = ppQ;
    pendView = '0;
    pendView[TIMER_BIT] = pendQ;
    cycleView = '0;
    cycleView[LOW_W-1:0] = cycleQ[LOW_W-1:0];
  end

  always_comb begin
    addrKnown = 1'b1;
    unique case (csrAddr)
      ADDR_STATUS:  rdOld = statusView;
      ADDR_ISA:     rdOld = ISA_WORD;
      ADDR_IE:      rdOld = enQ;
      ADDR_TVEC:    rdOld = tvecQ;
      ADDR_SCRATCH: rdOld = scratchQ;
      ADDR_EPC:     rdOld = epcQ;
      ADDR_CAUSE:   rdOld = causeQ;
      ADDR_TVAL:    rdOld = tvalQ;
      ADDR_IP:      rdOld = pendView;
      ADDR_CYCLE:   rdOld = cycleView;
      ADDR_VENDOR:  rdOld = VENDOR_WORD;
      default: begin
        rdOld     = '0;
        addrKnown = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleQ   <= '0;
      ieQ      <= 1'b0;
      pieQ     <= 1'b0;
      ppQ      <= PRIV_U;
      privQ    <= PRIV_M;
      pendQ    <= 1'b0;
      sleepQ   <= 1'b0;
      enQ      <= '0;
      tvecQ    <= '0;
      scratchQ <= '0;
      epcQ     <= '0;
      causeQ   <= '0;
      tvalQ    <= '0;
    end else begin
      cycleQ <= cycleQ + 1'b1;
      pendQ  <= timerPending;
      if (strobe.wfi)        sleepQ <= 1'b1;
      else if (timerPending) sleepQ <= 1'b0;

      if (strobe.trapEnter) begin
        epcQ   <= instPc;
        causeQ <= trapCause;
        tvalQ  <= trapTval;
        pieQ   <= ieQ;
        ieQ    <= 1'b0;
        ppQ    <= privQ;
        privQ  <= PRIV_M;
      end else if (strobe.mret) begin
        ieQ   <= pieQ;
        pieQ  <= 1'b1;
        ppQ   <= PRIV_U;
        privQ <= ppQ;
      end else if (strobe.wfi) begin
        ieQ <= 1'b1;
      end else if (strobe.csrWrite) begin
        case (csrAddr)
          ADDR_STATUS: begin
            ieQ  <= csrNewVal[ST_IE];
            pieQ <= csrNewVal[ST_PIE];
            ppQ  <= csrNewVal[ST_PP +: 2];
          end
          ADDR_IE:      enQ      <= csrNewVal;
          ADDR_TVEC:    tvecQ    <= csrNewVal;
          ADDR_SCRATCH: scratchQ <= csrNewVal;
          ADDR_EPC:     epcQ     <= csrNewVal;
          ADDR_CAUSE:   causeQ   <= csrNewVal;
          ADDR_TVAL:    tvalQ    <= csrNewVal;
          default: ;
        endcase
      end
    end
  end

  assign tvecOut   = tvecQ;
  assign epcOut    = epcQ;
  assign statusIe  = ieQ;
  assign privOut   = privQ;
  assign pendTimer = pendQ;
  assign enTimer   = enQ[TIMER_BIT];
  assign sleepOut  = sleepQ;

  // R5: trap entry lands in machine mode with the enable stacked
  a_r5_trap_stack: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapEnter |=> (privQ == PRIV_M) && !ieQ && (pieQ == $past(ieQ)));

  // R9: return pops the stack
  a_r9_ret_pop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mret |=> pieQ && (ppQ == PRIV_U) && (privQ == $past(ppQ)) && (ieQ == $past(pieQ)));

  // R8: interrupt capture values
  a_r8_irq_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trapEnter && strobe.trapIrq) |=> (causeQ == TIMER_CAUSE) && (tvalQ == '0));

  // R10: sleep only starts from a WFI
  a_r10_sleep_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepQ) |-> $past(strobe.wfi));

  // R12: counter steps by one every clock
  a_r12_cycle_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cycleQ == $past(cycleQ) + 1'b1);

  // R4: read-only words never change
  a_r4_const_words: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADDR_ISA) |-> (rdOld == ISA_WORD) && addrKnown);

endmodule

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               csrValid,
  input  logic [2:0]         csrOp,
  input  word_t              csrSrc,
  input  logic [4:0]         csrImm,
  input  word_t              rdOld,
  input  logic               addrKnown,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  word_t              excAddr,
  input  logic               sysValid,
  input  logic [1:0]         sysKind,
  input  word_t              instPc,
  input  logic [1:0]         privLevel,
  input  logic               statusIe,
  input  logic               pendTimer,
  input  logic               enTimer,
  input  word_t              tvec,
  input  word_t              epc,
  output ctlStrobe_t         strobe,
  output word_t              trapCause,
  output word_t              trapTval,
  output word_t              csrNewVal,
  output word_t              csrRdata,
  output logic               csrIllegal,
  output logic               redirectValid,
  output word_t              redirectPc,
  output logic               rdKill
);

  localparam int PAD_W = XLEN - CAUSE_W;

  sysKind_e kind;
  logic     opLegal, irqTake, excTake, sysSlot, csrSlot;
  logic     sysTrap, illTrap;
  word_t    excWord, srcVal;

  assign kind    = sysKind_e'(sysKind);
  assign excWord = {{PAD_W{1'b0}}, excCause};
  assign opLegal = (csrOp[1:0] != 2'b00);

  assign csrIllegal = csrValid && !(addrKnown && opLegal);
  assign csrRdata   = (csrValid && addrKnown) ? rdOld : '0;

  // priority: interrupt, pipeline exception, system op, CSR access
  assign irqTake = pendTimer && enTimer && statusIe;
  assign excTake = !irqTake && excValid;
  assign sysSlot = !irqTake && !excValid && sysValid;
  assign csrSlot = !irqTake && !excValid && !sysValid && csrValid;
  assign sysTrap = sysSlot && ((kind == SYS_CALL) || (kind == SYS_BREAK));
  assign illTrap = csrSlot && csrIllegal;

  always_comb begin
    strobe.trapIrq   = irqTake;
    strobe.trapEnter = irqTake || excTake || sysTrap || illTrap;
    strobe.mret      = sysSlot && (kind == SYS_RET);
    strobe.wfi       = sysSlot && (kind == SYS_SLEEP);
    strobe.csrWrite  = csrSlot && !csrIllegal;
  end

  always_comb begin
    if (irqTake)        trapCause = TIMER_CAUSE;
    else if (excTake)   trapCause = excWord;
    else if (sysTrap)   trapCause = (kind == SYS_BREAK) ? CAUSE_BREAK :
                                    (privLevel == PRIV_M) ? CAUSE_CALL_M : CAUSE_CALL_U;
    else                trapCause = CAUSE_ILLEGAL;
  end

  always_comb begin
    if (irqTake)
      trapTval = '0;
    else if (excTake && excWord >= 32'd5 && excWord <= 32'd7)
      trapTval = excAddr;
    else
      trapTval = instPc;
  end

  always_comb begin
    srcVal = csrOp[2] ? {{(XLEN-5){1'b0}}, csrImm} : csrSrc;
    unique case (csrOp[1:0])
      2'b01:   csrNewVal = srcVal;
      2'b10:   csrNewVal = rdOld | srcVal;
      2'b11:   csrNewVal = rdOld & ~srcVal;
      default: csrNewVal = rdOld;
    endcase
  end

  always_comb begin
    redirectValid = 1'b1;
    if (strobe.trapEnter)  redirectPc = tvec;
    else if (strobe.mret)  redirectPc = epc;
    else if (strobe.wfi)   redirectPc = instPc + 32'd4;
    else begin
      redirectValid = 1'b0;
      redirectPc    = '0;
    end
  end

  assign rdKill = strobe.trapEnter;

endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter int CYCLE_W = 64,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrValid,
  input  logic [11:0]        csrAddr,
  input  logic [2:0]         csrOp,
  input  logic [31:0]        csrSrc,
  input  logic [4:0]         csrImm,
  output logic [31:0]        csrRdata,
  output logic               csrIllegal,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [31:0]        excAddr,
  input  logic               sysValid,
  input  logic [1:0]         sysKind,
  input  logic [31:0]        instPc,
  input  logic               timerPending,
  output logic               redirectValid,
  output logic [31:0]        redirectPc,
  output logic               rdKill,
  output logic [1:0]         privLevel,
  output logic               sleeping
);

  ctlStrobe_t strobe;
  word_t      trapCause, trapTval, csrNewVal, rdOld, tvec, epc;
  logic       addrKnown, statusIe, pendTimer, enTimer;

  mcsr_ctrl #(.CAUSE_W(CAUSE_W)) u_ctrl (
    .csrValid(csrValid), .csrOp(csrOp), .csrSrc(csrSrc), .csrImm(csrImm),
    .rdOld(rdOld), .addrKnown(addrKnown),
    .excValid(excValid), .excCause(excCause), .excAddr(excAddr),
    .sysValid(sysValid), .sysKind(sysKind), .instPc(instPc),
    .privLevel(privLevel), .statusIe(statusIe),
    .pendTimer(pendTimer), .enTimer(enTimer),
    .tvec(tvec), .epc(epc),
    .strobe(strobe), .trapCause(trapCause), .trapTval(trapTval),
    .csrNewVal(csrNewVal), .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .rdKill(rdKill)
  );

  mcsr_dpath #(.CYCLE_W(CYCLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .csrAddr(csrAddr),
    .csrNewVal(csrNewVal), .trapCause(trapCause), .trapTval(trapTval),
    .instPc(instPc), .timerPending(timerPending),
    .rdOld(rdOld), .addrKnown(addrKnown), .tvecOut(tvec), .epcOut(epc),
    .statusIe(statusIe), .privOut(privLevel),
    .pendTimer(pendTimer), .enTimer(enTimer), .sleepOut(sleeping)
  );

endmodule

// File: tb/mcsr_trap_unit_tb.sv
`timescale 1ns/1ps
module mcsr_trap_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrValid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [2:0]  csrOp = '0;
  logic [31:0] csrSrc = '0;
  logic [4:0]  csrImm = '0;
  logic [31:0] csrRdata;
  logic        csrIllegal;
  logic        excValid = 1'b0;
  logic [3:0]  excCause = '0;
  logic [31:0] excAddr = '0;
  logic        sysValid = 1'b0;
  logic [1:0]  sysKind = '0;
  logic [31:0] instPc = '0;
  logic        timerPending = 1'b0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        rdKill;
  logic [1:0]  privLevel;
  logic        sleeping;

  int total = 0;
  int bad = 0;
  logic [31:0] obsRd, obsRpc, v, v2;
  logic        obsIll, obsKill, obsRv;

  always #10 clk = ~clk;

  mcsr_trap_unit u_dut (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrAddr(csrAddr),
    .csrOp(csrOp), .csrSrc(csrSrc), .csrImm(csrImm), .csrRdata(csrRdata),
    .csrIllegal(csrIllegal), .excValid(excValid), .excCause(excCause),
    .excAddr(excAddr), .sysValid(sysValid), .sysKind(sysKind),
    .instPc(instPc), .timerPending(timerPending),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .rdKill(rdKill),
    .privLevel(privLevel), .sleeping(sleeping)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture();
    #5;
    obsRd = csrRdata; obsIll = csrIllegal; obsKill = rdKill;
    obsRv = redirectValid; obsRpc = redirectPc;
    @(posedge clk);
    #1;
    csrValid = 1'b0; excValid = 1'b0; sysValid = 1'b0;
  endtask

  task automatic doCsr(input logic [11:0] a, input logic [2:0] op,
                       input logic [31:0] src, input logic [4:0] imm, input logic [31:0] pc);
    @(negedge clk);
    csrValid = 1'b1; csrAddr = a; csrOp = op; csrSrc = src; csrImm = imm; instPc = pc;
    capture();
  endtask

  task automatic rdCsr(input logic [11:0] a, output logic [31:0] val);
    doCsr(a, 3'd2, 32'd0, 5'd0, 32'h8000_0000);
    val = obsRd;
  endtask

  task automatic wrCsr(input logic [11:0] a, input logic [31:0] val);
    doCsr(a, 3'd1, val, 5'd0, 32'h8000_0000);
  endtask

  task automatic doSys(input logic [1:0] k, input logic [31:0] pc);
    @(negedge clk);
    sysValid = 1'b1; sysKind = k; instPc = pc;
    capture();
  endtask

  task automatic doExc(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] addr);
    @(negedge clk);
    excValid = 1'b1; excCause = c; instPc = pc; excAddr = addr;
    capture();
  endtask

  task automatic idle();
    @(negedge clk);
    capture();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic isKnown(input int a);
    return a == 'h300 || a == 'h301 || a == 'h304 || a == 'h305 ||
           (a >= 'h340 && a <= 'h344) || a == 'hC00 || a == 'hF11;
  endfunction

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    #1;
    chk("R1 priv", {30'd0, privLevel}, 32'd3);
    chk("R1 sleep", {31'd0, sleeping}, 32'd0);
    rdCsr(12'h300, v); chk("R1 status", v, 32'd0);
    rdCsr(12'h304, v); chk("R1 ie", v, 32'd0);
    rdCsr(12'h344, v); chk("R1 ip", v, 32'd0);
    rdCsr(12'h342, v); chk("R1 cause", v, 32'd0);

    // R12 cycle counter
    rdCsr(12'hC00, v);
    repeat (7) @(posedge clk);
    rdCsr(12'hC00, v2);
    chk("R12 cycle delta", v2 - v, 32'd8);

    // R4 constant words
    rdCsr(12'h301, v); chk("R4 isa", v, 32'h4040_1101);
    rdCsr(12'hF11, v); chk("R4 vendor", v, 32'hFF0F_F0FF);
    wrCsr(12'h301, 32'hFFFF_FFFF); chk("R4 isa write no trap", {31'd0, obsKill}, 32'd0);
    wrCsr(12'hF11, 32'h0);
    wrCsr(12'hC00, 32'h0);
    rdCsr(12'h301, v); chk("R4 isa kept", v, 32'h4040_1101);
    rdCsr(12'hF11, v); chk("R4 vendor kept", v, 32'hFF0F_F0FF);
    rdCsr(12'hC00, v); chk("R4 cycle not cleared", {31'd0, v > 32'd20}, 32'd1);

    // R3 operation sweep on scratch
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 4; s++) begin
        for (int o = 1; o < 8; o++) begin
          logic [31:0] base, src, eff, exp;
          logic [4:0] imm;
          if (o == 4) continue;
          base = (b == 0) ? 32'h0 : (b == 1) ? 32'hFFFF_FFFF : (b == 2) ? 32'hA5A5_3C3C : 32'h1234_5678;
          src  = (s == 0) ? 32'h0 : (s == 1) ? 32'hFFFF_FFFF : (s == 2) ? 32'h0F0F_00FF : 32'h0000_001B;
          imm  = src[4:0] ^ 5'h15;
          eff  = (o >= 4) ? {27'd0, imm} : src;
          exp  = (o % 4 == 1) ? eff : (o % 4 == 2) ? (base | eff) : (base & ~eff);
          wrCsr(12'h340, base);
          doCsr(12'h340, o[2:0], src, imm, 32'h8000_0040);
          chk("R3 old value", obsRd, base);
          chk("R11 no kill on csr op", {31'd0, obsKill}, 32'd0);
          rdCsr(12'h340, v);
          chk("R3 result", v, exp);
        end
      end
    end

    // R13 status mask and pending register
    wrCsr(12'h300, 32'hFFFF_FFFF);
    rdCsr(12'h300, v); chk("R13 status mask", v, 32'h0000_1888);
    wrCsr(12'h300, 32'h0);
    wrCsr(12'h344, 32'hFFFF_FFFF);
    rdCsr(12'h344, v); chk("R13 ip write dropped", v, 32'h0);

    // R2 register distinctness
    wrCsr(12'h304, 32'h0000_0011);
    wrCsr(12'h305, 32'h0000_0400);
    wrCsr(12'h340, 32'h0000_3333);
    wrCsr(12'h341, 32'h8000_0044);
    wrCsr(12'h342, 32'h0000_0055);
    wrCsr(12'h343, 32'h0000_6666);
    rdCsr(12'h304, v); chk("R2 ie", v, 32'h0000_0011);
    rdCsr(12'h305, v); chk("R2 tvec", v, 32'h0000_0400);
    rdCsr(12'h340, v); chk("R2 scratch", v, 32'h0000_3333);
    rdCsr(12'h341, v); chk("R2 epc", v, 32'h8000_0044);
    rdCsr(12'h342, v); chk("R2 cause", v, 32'h0000_0055);
    rdCsr(12'h343, v); chk("R2 tval", v, 32'h0000_6666);

    // R2 illegal funct3 codes
    for (int o = 0; o < 8; o += 4) begin
      doCsr(12'h340, o[2:0], 32'h0, 5'd0, 32'h8000_0120 + o);
      chk("R2 bad op flag", {31'd0, obsIll}, 32'd1);
      chk("R11 bad op kill", {31'd0, obsKill}, 32'd1);
      chk("R2 bad op redirect", obsRpc, 32'h0000_0400);
      rdCsr(12'h342, v); chk("R2 bad op cause", v, 32'd2);
      rdCsr(12'h343, v); chk("R2 bad op tval", v, 32'h8000_0120 + o);
    end
    rdCsr(12'h340, v); chk("R2 bad op no write", v, 32'h0000_3333);

    // R2 full address sweep
    for (int a = 0; a < 4096; a++) begin
      doCsr(a[11:0], 3'd2, 32'h0, 5'd0, 32'h8000_0000);
      chk("R2 decode", {31'd0, obsIll}, {31'd0, !isKnown(a)});
    end

    // R5 R6 R7 exceptions
    doReset();
    wrCsr(12'h305, 32'h0000_0400);
    wrCsr(12'h300, 32'h0000_0008);
    doExc(4'd5, 32'h8000_0100, 32'h0000_1234);
    chk("R5 redirect valid", {31'd0, obsRv}, 32'd1);
    chk("R5 redirect to vector", obsRpc, 32'h0000_0400);
    chk("R11 exc kill", {31'd0, obsKill}, 32'd1);
    rdCsr(12'h300, v); chk("R5 status stack", v, 32'h0000_1880);
    rdCsr(12'h341, v); chk("R5 epc", v, 32'h8000_0100);
    for (int c = 0; c < 16; c++) begin
      doExc(c[3:0], 32'h8000_1000 + 4 * c, 32'hDEAD_0000 + c);
      rdCsr(12'h342, v); chk("R6 exc cause", v, c);
      rdCsr(12'h343, v);
      chk("R7 tval", v, (c >= 5 && c <= 7) ? 32'hDEAD_0000 + c : 32'h8000_1000 + 4 * c);
    end
    doSys(2'd0, 32'h8000_0180);
    rdCsr(12'h342, v); chk("R6 ecall machine", v, 32'd11);
    doSys(2'd1, 32'h8000_0184);
    rdCsr(12'h342, v); chk("R6 ebreak", v, 32'd3);
    rdCsr(12'h343, v); chk("R7 ebreak tval", v, 32'h8000_0184);

    // R9 return to user, then user ecall
    wrCsr(12'h300, 32'h0000_0080);
    wrCsr(12'h341, 32'h8000_0200);
    doSys(2'd2, 32'h8000_0190);
    chk("R9 redirect epc", obsRpc, 32'h8000_0200);
    chk("R11 mret no kill", {31'd0, obsKill}, 32'd0);
    #1 chk("R9 priv user", {30'd0, privLevel}, 32'd0);
    rdCsr(12'h300, v); chk("R9 status after", v, 32'h0000_0088);
    doSys(2'd0, 32'h8000_0204);
    #1 chk("R5 priv machine", {30'd0, privLevel}, 32'd3);
    rdCsr(12'h342, v); chk("R6 ecall user", v, 32'd8);
    rdCsr(12'h300, v); chk("R5 status from user", v, 32'h0000_0080);
    wrCsr(12'h300, 32'h0000_1800);
    doSys(2'd2, 32'h8000_0208);
    #1 chk("R9 priv machine", {30'd0, privLevel}, 32'd3);
    rdCsr(12'h300, v); chk("R9 status pie set", v, 32'h0000_0080);

    // R8 timer interrupt gating and priority
    wrCsr(12'h300, 32'h0000_0008);
    wrCsr(12'h304, 32'h0);
    timerPending = 1'b1;
    idle();
    idle(); chk("R8 masked by ie", {31'd0, obsRv}, 32'd0);
    wrCsr(12'h300, 32'h0);
    wrCsr(12'h304, 32'h0000_0080);
    idle(); chk("R8 masked by status", {31'd0, obsRv}, 32'd0);
    rdCsr(12'h344, v); chk("R13 ip follows timer", v, 32'h0000_0080);
    wrCsr(12'h300, 32'h0000_0008);
    doExc(4'd2, 32'h8000_0300, 32'h0);
    timerPending = 1'b0;
    chk("R8 irq redirect", obsRpc, 32'h0000_0400);
    chk("R11 irq kill", {31'd0, obsKill}, 32'd1);
    rdCsr(12'h342, v); chk("R8 irq cause", v, 32'h8000_0007);
    rdCsr(12'h343, v); chk("R8 irq tval", v, 32'h0);
    rdCsr(12'h341, v); chk("R8 irq epc", v, 32'h8000_0300);
    rdCsr(12'h300, v); chk("R8 irq status", v, 32'h0000_1880);

    // R10 wait for interrupt
    wrCsr(12'h304, 32'h0);
    wrCsr(12'h300, 32'h0);
    doSys(2'd3, 32'h8000_0500);
    chk("R10 redirect", obsRpc, 32'h8000_0504);
    chk("R11 wfi no kill", {31'd0, obsKill}, 32'd0);
    chk("R10 sleeping", {31'd0, sleeping}, 32'd1);
    rdCsr(12'h300, v); chk("R10 status ie", v, 32'h0000_0008);
    repeat (3) @(posedge clk);
    #1 chk("R10 still asleep", {31'd0, sleeping}, 32'd1);
    @(negedge clk) timerPending = 1'b1;
    @(posedge clk);
    #1 chk("R10 wake", {31'd0, sleeping}, 32'd0);
    timerPending = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule